// File: doc/BRIEF.md
# Parallel-to-Serial Word Framer

The framer takes a 22-bit parallel word, captured on each rising edge of a parallel-clock strobe, and sends it out one bit at a time on a single serial line. Bits advance only on cycles where a bit-rate enable is high. Each serial frame is 25 bits long and carries its own alignment marker. The frame opens with a bit that is always zero. The 22 data bits follow, lowest first. Two closing bits come last; both are the inverse of the top data bit, so every frame has at least one level change and a receiver can find the word boundary.

An active-low power-down input is passed through a synchroniser. While power-down is asserted, and after it is released until a start-up period of parallel-clock rising edges has been counted, the serial output is not driven: the output-enable flag is low and the data line is held low. Once the start-up period ends, a new captured word enters the shift register only when the bit position wraps from the last frame bit back to the first, so a frame in flight is never mixed with a newer word.

Top module: `word_framer`

## Requirements
- R1: After reset, soe_o and sdata_o are both 0.
- R2: Frame bit 0 (the first bit of every 25-bit frame) is always 0.
- R3: Frame bits 1 to 22 carry data bits 0 to 21 in that order, lowest first.
- R4: Frame bits 23 and 24 both equal the inverse of data bit 21, so there is no transition between them.
- R5: The bit position advances only on cycles with bit_en_i high, and it wraps after 25 enabled cycles. While bit_en_i is low, sdata_o holds its value.
- R6: After pd_ni is released, soe_o stays 0 until LOCK_CYCLES rising edges of pclk_i have been seen. It rises in the cycle of the last of these edges, and the first frame starts on the next enabled cycle.
- R7: No later than three clock edges after pd_ni goes low, soe_o and sdata_o are 0, and they stay 0 while pd_ni is low.
- R8: data_i is sampled only at a rising edge of pclk_i. Changes to data_i between rising edges do not reach the serial frame.
- R9: A new word is loaded only when the bit position wraps from 24 to 0, so every bit of one frame comes from the same captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pd_ni | input | 1 | Power-down, active low, asynchronous to clk_i |
| bit_en_i | input | 1 | Serial bit enable |
| pclk_i | input | 1 | Parallel-clock strobe, sampled in clk_i domain |
| data_i | input | DATA_W | Parallel data word |
| sdata_o | output | 1 | Serial frame data |
| soe_o | output | 1 | Serial output enable |

## Verification
The hardest case to reach from the ports is a frame that must stay whole while the input keeps changing. In that case data_i holds the expected word only in the one cycle where pclk_i rises, and the bench drives its complement in every other cycle. Any leak of off-edge data or any mid-frame load then shows up as a wrong bit. A second case stalls bit_en_i for exactly one frame length in the middle of a frame. This checks that the output holds still and that frame alignment to the parallel clock survives the stall. Power-down is applied after the framer is already locked, which shows that the start-up count restarts from zero.

// File: rtl/word_framer_pkg.sv
package word_framer_pkg;
  localparam int unsigned LEAD_BITS  = 1;
  localparam int unsigned BOUND_BITS = 2;

  function automatic int unsigned frame_len(input int unsigned dw);
    return dw + LEAD_BITS + BOUND_BITS;
  endfunction
endpackage

// File: rtl/wf_sync.sv
module wf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/wf_capture.sv
module wf_capture #(
  parameter int unsigned DATA_W = 22
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pclk_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rise_o,
  output logic [DATA_W-1:0] word_o
);
  logic pclk_q;

  assign rise_o = pclk_i & ~pclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pclk_q <= 1'b0;
      word_o <= '0;
    end else begin
      pclk_q <= pclk_i;
      if (rise_o) word_o <= data_i;
    end
  end
endmodule

// File: rtl/wf_lock.sv
module wf_lock #(
  parameter int unsigned LOCK_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic locked_o
);
  localparam int unsigned CW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
    end else if (!run_i) begin
      cnt_q    <= '0;
      locked_o <= 1'b0;
    end else if (tick_i && !locked_o) begin
      if (cnt_q == LAST) locked_o <= 1'b1;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/wf_shifter.sv
module wf_shifter
  import word_framer_pkg::*;
#(
  parameter int unsigned DATA_W = 22,
  localparam int unsigned FL = frame_len(DATA_W),
  localparam int unsigned CW = $clog2(FL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              bit_en_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              sdata_o,
  output logic [CW-1:0]     bit_cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(FL - 1);

  logic [FL-1:0] sh_q;
  logic [FL-1:0] next_frame;

  // lead zero at LSB, data LSB-first, two inverted boundary bits at top
  assign next_frame = {{BOUND_BITS{~word_i[DATA_W-1]}}, word_i, {LEAD_BITS{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q      <= '0;
      bit_cnt_o <= LAST;
    end else if (!active_i) begin
      sh_q      <= '0;
      bit_cnt_o <= LAST;
    end else if (bit_en_i) begin
      if (bit_cnt_o == LAST) begin
        sh_q      <= next_frame;
        bit_cnt_o <= '0;
      end else begin
        sh_q      <= {1'b0, sh_q[FL-1:1]};
        bit_cnt_o <= bit_cnt_o + 1'b1;
      end
    end
  end

  assign sdata_o = sh_q[0];
endmodule

// File: rtl/word_framer.sv
module word_framer
  import word_framer_pkg::*;
#(
  parameter int unsigned DATA_W      = 22,
  parameter int unsigned LOCK_CYCLES = 4096,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pd_ni,
  input  logic              bit_en_i,
  input  logic              pclk_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              sdata_o,
  output logic              soe_o
);
  localparam int unsigned CW = $clog2(frame_len(DATA_W));

  logic              run_s;
  logic              pclk_rise;
  logic [DATA_W-1:0] held_word;
  logic              locked;
  logic              sh_bit;
  logic [CW-1:0]     bit_cnt;

  wf_sync #(.STAGES(SYNC_STAGES)) u_pd_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_ni),
    .q_o   (run_s)
  );

  wf_capture #(.DATA_W(DATA_W)) u_capture (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pclk_i(pclk_i),
    .data_i(data_i),
    .rise_o(pclk_rise),
    .word_o(held_word)
  );

  wf_lock #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_s),
    .tick_i  (pclk_rise),
    .locked_o(locked)
  );

  wf_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (locked),
    .bit_en_i (bit_en_i),
    .word_i   (held_word),
    .sdata_o  (sh_bit),
    .bit_cnt_o(bit_cnt)
  );

  assign soe_o   = locked;
  assign sdata_o = locked & sh_bit;
endmodule

// File: rtl/word_framer_chk.sv
module word_framer_chk #(
  parameter int unsigned CW = 5,
  parameter int unsigned FL = 25
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pd_ni,
  input logic          bit_en_i,
  input logic          sdata_o,
  input logic          soe_o,
  input logic [CW-1:0] bit_cnt
);
  logic [2:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk_i)
    !rst_ni |-> !soe_o && !sdata_o);

  assert_lead_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soe_o && bit_cnt == '0 |-> !sdata_o);

  assert_bound_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soe_o && bit_en_i && bit_cnt == CW'(FL - 3) |=> !soe_o || sdata_o != $past(sdata_o));

  assert_bound_pair_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soe_o && bit_en_i && bit_cnt == CW'(FL - 2) |=> !soe_o || sdata_o == $past(sdata_o));

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q != 3'd0 && soe_o && $past(soe_o) && !$past(bit_en_i) |-> $stable(sdata_o));

  assert_cnt_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= CW'(FL - 1));

  assert_pd_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    age_q >= 3'd4 && !pd_ni && !$past(pd_ni) && !$past(pd_ni, 2) && !$past(pd_ni, 3)
    |-> !soe_o && !sdata_o);
endmodule

bind word_framer word_framer_chk #(
  .CW(CW),
  .FL(word_framer_pkg::frame_len(DATA_W))
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pd_ni   (pd_ni),
  .bit_en_i(bit_en_i),
  .sdata_o (sdata_o),
  .soe_o   (soe_o),
  .bit_cnt (bit_cnt)
);

// File: tb/word_framer_tb_top.sv
`timescale 1ns/1ps
module word_framer_tb_top;
  localparam int unsigned DW   = 22;
  localparam int unsigned LOCK = 8;
  localparam int unsigned FL   = DW + 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          pd_ni = 1'b0;
  logic          bit_en_i = 1'b1;
  logic          pclk_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          sdata_o;
  logic          soe_o;

  int checks = 0;
  int fails  = 0;
  int ph     = 0;
  bit gen_on = 1'b0;
  bit junk   = 1'b0;
  logic [DW-1:0] word = '0;
  int cycles = 0;

  always #10 clk = ~clk;

  word_framer #(.DATA_W(DW), .LOCK_CYCLES(LOCK)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni), .bit_en_i(bit_en_i),
    .pclk_i(pclk_i), .data_i(data_i), .sdata_o(sdata_o), .soe_o(soe_o)
  );

  // parallel clock: 25 bit periods, rising at the edge after ph becomes 0
  always @(negedge clk) begin
    if (gen_on) begin
      ph = (ph == FL - 1) ? 0 : ph + 1;
      pclk_i <= (ph < 12);
      data_i <= (ph == 0 || !junk) ? word : ~word;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ph(input int k);
    do @(posedge clk); while (ph != k);
  endtask

  task automatic t_reset();
    #5;
    chk(soe_o == 1'b0, "R1 soe_o", soe_o, 0);
    chk(sdata_o == 1'b0, "R1 sdata_o", sdata_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    gen_on = 1'b1;
  endtask

  task automatic t_lock();
    wait_ph(1);
    @(negedge clk); pd_ni = 1'b1;
    for (int k = 1; k <= LOCK; k++) begin
      wait_ph(0);
      @(negedge clk);
      chk(soe_o == (k == LOCK), "R6 soe_o after pclk rise", soe_o, int'(k == LOCK));
    end
  endtask

  // checks two consecutive frames of the held word
  task automatic t_frame(input logic [DW-1:0] w, input bit j);
    logic [FL-1:0] exp;
    word = w; junk = j;
    exp = {~w[DW-1], ~w[DW-1], w, 1'b0};
    repeat (3) wait_ph(1);
    for (int i = 0; i < 2 * FL; i++) begin
      int b;
      b = i % FL;
      @(negedge clk);
      if (b == 0)
        chk(sdata_o == 1'b0, "R2 lead bit", sdata_o, 0);
      else if (b <= DW)
        chk(sdata_o == exp[b], j ? "R8 R9 data bit" : "R3 data bit", sdata_o, exp[b]);
      else
        chk(sdata_o == exp[b], "R4 boundary bit", sdata_o, exp[b]);
      chk(soe_o == 1'b1, "R5 soe_o during frames", soe_o, 1);
    end
  endtask

  task automatic t_stall(input logic [DW-1:0] w);
    logic held;
    wait_ph(7);
    @(negedge clk); bit_en_i = 1'b0;
    @(negedge clk); held = sdata_o;
    for (int i = 0; i < FL - 1; i++) begin
      @(negedge clk);
      chk(sdata_o == held, "R5 hold while bit_en_i low", sdata_o, held);
    end
    bit_en_i = 1'b1;
    t_frame(w, 1'b0);
  endtask

  task automatic t_pd();
    @(negedge clk); pd_ni = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < FL; i++) begin
      chk(soe_o == 1'b0, "R7 soe_o in power-down", soe_o, 0);
      chk(sdata_o == 1'b0, "R7 sdata_o in power-down", sdata_o, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_lock();
    t_frame(22'h2A_5A5B, 1'b0);
    t_frame(22'h15_A5A4, 1'b0);
    t_frame(22'h3F_FFFF, 1'b0);
    t_frame(22'h00_0000, 1'b0);
    t_frame(22'h1C_3C71, 1'b1);
    t_frame(22'h23_0F0E, 1'b1);
    t_stall(22'h11_2233);
    t_pd();
    t_lock();
    t_frame(22'h2B_CDEF, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule